// File: doc/BRIEF.md
# In-Order Superscalar Issue Grouper

This block sits between decode and the execution units of an in-order superscalar core. Each cycle it looks at a window of up to six decoded instructions in program order. It chooses the longest leading run of them that can start together. A run ends at the first instruction that would break a rule. The rules are: a total group width of four; caps per instruction class of two integer, two floating-point/graphics, one memory and one branch; source operands that are still pending in the scoreboard; a read of a register written earlier in the same window; and an empty slot.

The block reports the group as a per-slot enable vector and a count from 0 to 4. The enable vector is always a contiguous run starting at slot 0. Upstream logic shifts the window by the count, so every instruction that did not issue comes back in the next cycle. The block keeps its own scoreboard of pending registers. Each issued instruction marks its destination busy, and a writeback port clears busy registers.

Top module: `issue_grouper`

## Requirements
- R1: After reset, every register is free, and an all-empty window issues nothing (count 0).
- R2: No more than four instructions issue in one cycle, even when all six slots could go.
- R3: At most two instructions of class integer (code 0) issue in one group.
- R4: At most two instructions of class floating-point/graphics (code 1) issue in one group.
- R5: At most one memory instruction (code 2) and at most one branch (code 3) issue in one group.
- R6: Issue is strictly in order. The enable vector has ones in slots 0 to count-1 and nowhere else. The first slot that cannot go stops every later slot, even a later slot that could go on its own.
- R7: A slot whose valid bit is low ends the group at that slot.
- R8: A slot that reads a register marked busy does not issue, and neither does any slot after it.
- R9: A slot that reads a register written by an earlier slot of the same window ends the group at that slot.
- R10: The nonzero destination of an issued instruction reads as busy from the next cycle onward.
- R11: A writeback clears its register from the next cycle onward. The cycle of the writeback still sees the register busy. If an instruction that issues in the same cycle writes the same register, the register stays busy.
- R12: Register tag 0 means "no register". It is never busy, and it never creates a dependency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotValid | input | 6 | Valid bit per window slot, slot 0 oldest |
| slotClass | input | 12 | 2-bit class per slot: 0 int, 1 fp/graphics, 2 memory, 3 branch |
| slotSrcA | input | 30 | First source tag per slot (5 bits each) |
| slotSrcB | input | 30 | Second source tag per slot |
| slotDst | input | 30 | Destination tag per slot, 0 for none |
| wbValid | input | 1 | Writeback strobe |
| wbTag | input | 5 | Register released by the writeback |
| issueEn | output | 6 | Per-slot issue enable, contiguous from slot 0 |
| issueCount | output | 3 | Number of slots issued, 0 to 4 |

## Verification
The issue enables and the count are combinational in the current window and the registered scoreboard, so they are due in the same cycle as the window. The bench drives inputs on the falling edge and compares shortly after, well before the next rising edge. Changes to the scoreboard caused by issue or writeback take effect only at the next rising edge. The bench's behavioural model therefore updates its own busy set after that edge, and the directed checks look for a busy or freed register one cycle after the event that caused it. Directed windows with hand-computed counts cover each cap and each hazard. A long run of random windows with random writebacks is then compared cycle by cycle against the model.

// File: rtl/issue_grp_pkg.sv
package issue_grp_pkg;

  // Upper bound on window size carried in the strobe struct
  localparam int SLOT_MAX = 8;

  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_FPG = 2'd1,
    CLS_MEM = 2'd2,
    CLS_BR  = 2'd3
  } instClass_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [SLOT_MAX-1:0] issueEn;
    logic                anyIssue;
  } grpStrobe_t;

endpackage

// File: rtl/issue_grp_dp.sv
module issue_grp_dp
  import issue_grp_pkg::*;
#(
  parameter int SLOTS = 6,
  parameter int NREG  = 32,
  parameter int TAGW  = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [SLOTS*TAGW-1:0] slotSrcA,
  input  logic [SLOTS*TAGW-1:0] slotSrcB,
  input  logic [SLOTS*TAGW-1:0] slotDst,
  input  logic                  wbValid,
  input  logic [TAGW-1:0]       wbTag,
  input  grpStrobe_t            strobe,
  output logic [SLOTS-1:0]      slotReady
);

  logic [NREG-1:0] busyQ, busyD;
  logic [TAGW-1:0] srcATag [SLOTS];
  logic [TAGW-1:0] srcBTag [SLOTS];
  logic [TAGW-1:0] dstTag  [SLOTS];
  logic [SLOTS-1:0] srcPending;
  logic [SLOTS-1:0] inGroupRaw;

  genvar gi;
  generate
    for (gi = 0; gi < SLOTS; gi++) begin : g_slot
      assign srcATag[gi] = slotSrcA[gi*TAGW +: TAGW];
      assign srcBTag[gi] = slotSrcB[gi*TAGW +: TAGW];
      assign dstTag[gi]  = slotDst[gi*TAGW +: TAGW];

      // Scoreboard lookup, tag 0 is never pending
      assign srcPending[gi] = ((srcATag[gi] != '0) && busyQ[srcATag[gi]]) ||
                              ((srcBTag[gi] != '0) && busyQ[srcBTag[gi]]);

      // Read-after-write against older slots of the same window
      always_comb begin
        inGroupRaw[gi] = 1'b0;
        for (int j = 0; j < gi; j++) begin
          if (dstTag[j] != '0 &&
              (dstTag[j] == srcATag[gi] || dstTag[j] == srcBTag[gi]))
            inGroupRaw[gi] = 1'b1;
        end
      end

      assign slotReady[gi] = !srcPending[gi] && !inGroupRaw[gi];

      // R10
      issued_dst_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.issueEn[gi] && dstTag[gi] != '0) |=> busyQ[$past(dstTag[gi])]);

      // R8
      no_pending_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
        strobe.issueEn[gi] |->
          !((srcATag[gi] != '0 && busyQ[srcATag[gi]]) ||
            (srcBTag[gi] != '0 && busyQ[srcBTag[gi]])));
    end
  endgenerate

  // Next scoreboard: release first, then issued destinations win
  always_comb begin
    busyD = busyQ;
    if (wbValid) busyD[wbTag] = 1'b0;
    if (strobe.anyIssue) begin
      for (int i = 0; i < SLOTS; i++) begin
        if (strobe.issueEn[i] && dstTag[i] != '0) busyD[dstTag[i]] = 1'b1;
      end
    end
    busyD[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) busyQ <= '0;
    else       busyQ <= busyD;
  end

  logic wbHitsIssue;
  always_comb begin
    wbHitsIssue = 1'b0;
    for (int i = 0; i < SLOTS; i++)
      if (strobe.issueEn[i] && dstTag[i] == wbTag) wbHitsIssue = 1'b1;
  end

  // R11
  wb_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !wbHitsIssue) |=> !busyQ[$past(wbTag)]);

  // R12
  zero_tag_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ[0]);

endmodule

// File: rtl/issue_grp_ctl.sv
module issue_grp_ctl
  import issue_grp_pkg::*;
#(
  parameter int SLOTS   = 6,
  parameter int WIDTH   = 4,
  parameter int INT_CAP = 2,
  parameter int FPG_CAP = 2,
  parameter int MEM_CAP = 1,
  parameter int BR_CAP  = 1,
  parameter int CNTW    = $clog2(WIDTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SLOTS-1:0]   slotValid,
  input  logic [SLOTS*2-1:0] slotClass,
  input  logic [SLOTS-1:0]   slotReady,
  output grpStrobe_t         strobe,
  output logic [CNTW-1:0]    issueCount
);

  instClass_e       cls [SLOTS];
  logic [SLOTS-1:0] isInt, isFpg, isMem, isBr;
  logic [SLOTS-1:0] grpEn;

  genvar gi;
  generate
    for (gi = 0; gi < SLOTS; gi++) begin : g_cls
      assign cls[gi]   = instClass_e'(slotClass[gi*2 +: 2]);
      assign isInt[gi] = (cls[gi] == CLS_INT);
      assign isFpg[gi] = (cls[gi] == CLS_FPG);
      assign isMem[gi] = (cls[gi] == CLS_MEM);
      assign isBr[gi]  = (cls[gi] == CLS_BR);

      // R7
      en_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
        grpEn[gi] |-> slotValid[gi]);
    end
  endgenerate

  // Walk the window oldest first; the first refusal closes the group
  always_comb begin
    int  nTot, nInt, nFpg, nMem, nBr;
    logic open, capOk;
    nTot = 0; nInt = 0; nFpg = 0; nMem = 0; nBr = 0;
    open  = 1'b1;
    grpEn = '0;
    for (int i = 0; i < SLOTS; i++) begin
      unique case (cls[i])
        CLS_INT: capOk = (nInt < INT_CAP);
        CLS_FPG: capOk = (nFpg < FPG_CAP);
        CLS_MEM: capOk = (nMem < MEM_CAP);
        default: capOk = (nBr  < BR_CAP);
      endcase
      if (open && slotValid[i] && slotReady[i] && capOk && nTot < WIDTH) begin
        grpEn[i] = 1'b1;
        nTot++;
        if (isInt[i]) nInt++;
        if (isFpg[i]) nFpg++;
        if (isMem[i]) nMem++;
        if (isBr[i])  nBr++;
      end else begin
        open = 1'b0;
      end
    end
    issueCount = CNTW'(nTot);
  end

  assign strobe.issueEn  = SLOT_MAX'(grpEn);
  assign strobe.anyIssue = |grpEn;

  // R6
  prefix_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((({1'b0, grpEn}) + 1'b1) & {1'b0, grpEn}) == '0);

  // R6
  count_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(grpEn) == int'(issueCount));

  // R2
  width_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(issueCount) <= WIDTH);

  // R3
  int_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(grpEn & isInt) <= INT_CAP);

  // R4
  fpg_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(grpEn & isFpg) <= FPG_CAP);

  // R5
  mem_br_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(grpEn & isMem) <= MEM_CAP) && ($countones(grpEn & isBr) <= BR_CAP));

endmodule

// File: rtl/issue_grouper.sv
module issue_grouper
  import issue_grp_pkg::*;
#(
  parameter int SLOTS   = 6,
  parameter int WIDTH   = 4,
  parameter int INT_CAP = 2,
  parameter int FPG_CAP = 2,
  parameter int MEM_CAP = 1,
  parameter int BR_CAP  = 1,
  parameter int NREG    = 32,
  localparam int TAGW   = $clog2(NREG),
  localparam int CNTW   = $clog2(WIDTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [SLOTS-1:0]      slotValid,
  input  logic [SLOTS*2-1:0]    slotClass,
  input  logic [SLOTS*TAGW-1:0] slotSrcA,
  input  logic [SLOTS*TAGW-1:0] slotSrcB,
  input  logic [SLOTS*TAGW-1:0] slotDst,
  input  logic                  wbValid,
  input  logic [TAGW-1:0]       wbTag,
  output logic [SLOTS-1:0]      issueEn,
  output logic [CNTW-1:0]       issueCount
);

  grpStrobe_t       strobe;
  logic [SLOTS-1:0] slotReady;

  issue_grp_dp #(.SLOTS(SLOTS), .NREG(NREG), .TAGW(TAGW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .slotSrcA  (slotSrcA),
    .slotSrcB  (slotSrcB),
    .slotDst   (slotDst),
    .wbValid   (wbValid),
    .wbTag     (wbTag),
    .strobe    (strobe),
    .slotReady (slotReady)
  );

  issue_grp_ctl #(
    .SLOTS(SLOTS), .WIDTH(WIDTH), .INT_CAP(INT_CAP), .FPG_CAP(FPG_CAP),
    .MEM_CAP(MEM_CAP), .BR_CAP(BR_CAP), .CNTW(CNTW)
  ) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .slotValid  (slotValid),
    .slotClass  (slotClass),
    .slotReady  (slotReady),
    .strobe     (strobe),
    .issueCount (issueCount)
  );

  assign issueEn = strobe.issueEn[SLOTS-1:0];

endmodule

// File: tb/issue_grouper_test.sv
`timescale 1ns/1ps
module issue_grouper_test;

  localparam int NS = 6;
  localparam int TW = 5;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NS-1:0]   slotValid = '0;
  logic [NS*2-1:0] slotClass = '0;
  logic [NS*TW-1:0] slotSrcA = '0, slotSrcB = '0, slotDst = '0;
  logic            wbValid = 1'b0;
  logic [TW-1:0]   wbTag = '0;
  logic [NS-1:0]   issueEn;
  logic [2:0]      issueCount;

  always #10 clk = ~clk;  // 50 MHz

  issue_grouper uut (
    .clk(clk), .rstN(rstN), .slotValid(slotValid), .slotClass(slotClass),
    .slotSrcA(slotSrcA), .slotSrcB(slotSrcB), .slotDst(slotDst),
    .wbValid(wbValid), .wbTag(wbTag), .issueEn(issueEn), .issueCount(issueCount)
  );

  // Behavioural window description
  bit       v [NS];
  int       c [NS];
  int       a [NS], b [NS], d [NS];
  bit       refBusy [32];
  int       checks = 0, errors = 0;
  bit       done = 0;

  task automatic clearSlots();
    for (int i = 0; i < NS; i++) begin v[i] = 0; c[i] = 0; a[i] = 0; b[i] = 0; d[i] = 0; end
    wbValid = 1'b0; wbTag = '0;
  endtask

  task automatic setSlot(input int i, input int cl, input int sa, input int sb, input int dt);
    v[i] = 1; c[i] = cl; a[i] = sa; b[i] = sb; d[i] = dt;
  endtask

  function automatic int modelIssue();
    int n = 0;
    int used [4] = '{0, 0, 0, 0};
    int caps [4] = '{2, 2, 1, 1};
    for (int i = 0; i < NS; i++) begin
      bit blocked = 0;
      if (!v[i] || n == 4 || used[c[i]] >= caps[c[i]]) break;
      if (a[i] != 0 && refBusy[a[i]]) blocked = 1;
      if (b[i] != 0 && refBusy[b[i]]) blocked = 1;
      for (int j = 0; j < i; j++)
        if (d[j] != 0 && (d[j] == a[i] || d[j] == b[i])) blocked = 1;
      if (blocked) break;
      used[c[i]]++;
      n++;
    end
    return n;
  endfunction

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive at falling edge, compare mid-cycle, advance model after rising edge
  task automatic step(input string tag, input int expN);
    int m;
    logic [NS-1:0] expEn;
    for (int i = 0; i < NS; i++) begin
      slotValid[i] = v[i];
      slotClass[i*2 +: 2] = c[i][1:0];
      slotSrcA[i*TW +: TW] = a[i][TW-1:0];
      slotSrcB[i*TW +: TW] = b[i][TW-1:0];
      slotDst[i*TW +: TW]  = d[i][TW-1:0];
    end
    #2;
    m = modelIssue();
    expEn = '0;
    for (int i = 0; i < m; i++) expEn[i] = 1'b1;
    check(tag, int'(issueCount) == m, int'(issueCount), m);
    check(tag, issueEn == expEn, int'(issueEn), int'(expEn));
    if (expN >= 0) check(tag, int'(issueCount) == expN, int'(issueCount), expN);
    @(posedge clk);
    if (wbValid) refBusy[wbTag] = 0;
    for (int i = 0; i < m; i++) if (d[i] != 0) refBusy[d[i]] = 1;
    refBusy[0] = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 32; r++) refBusy[r] = 0;
    clearSlots();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: empty window, then a read of r5 after reset is free
    step("R1", 0);
    setSlot(0, 0, 5, 31, 0); step("R1", 1);

    // R2: one of every class plus spare, six independent
    clearSlots();
    setSlot(0,0,1,2,0); setSlot(1,0,1,2,0); setSlot(2,1,1,2,0);
    setSlot(3,1,1,2,0); setSlot(4,2,1,2,0); setSlot(5,3,1,2,0);
    step("R2", 4);

    // R3: third integer stops the group
    clearSlots();
    setSlot(0,0,1,2,0); setSlot(1,0,1,2,0); setSlot(2,0,1,2,0); setSlot(3,1,1,2,0);
    step("R3", 2);

    // R4: third fp/graphics stops the group
    clearSlots();
    setSlot(0,1,1,2,0); setSlot(1,1,1,2,0); setSlot(2,1,1,2,0); setSlot(3,0,1,2,0);
    step("R4", 2);

    // R5: memory cap then branch cap
    clearSlots();
    setSlot(0,2,1,2,0); setSlot(1,2,1,2,0);
    step("R5", 1);
    clearSlots();
    setSlot(0,3,1,2,0); setSlot(1,0,1,2,0); setSlot(2,3,1,2,0);
    step("R5", 2);

    // R6: second branch blocks a later integer that could go alone
    clearSlots();
    setSlot(0,3,1,2,0); setSlot(1,3,1,2,0); setSlot(2,0,1,2,0);
    step("R6", 1);

    // R7: hole in the window
    clearSlots();
    setSlot(0,0,1,2,0); setSlot(2,0,1,2,0);
    step("R7", 1);

    // R9: read of an older slot's destination
    clearSlots();
    setSlot(0,0,1,2,3); setSlot(1,0,3,2,0);
    step("R9", 1);

    // R10: r3 now busy
    clearSlots();
    setSlot(0,0,1,3,0);
    step("R10", 0);
    // R11: writeback cycle still sees busy, next cycle free
    wbValid = 1'b1; wbTag = 5'd3;
    step("R11", 0);
    wbValid = 1'b0;
    step("R11", 1);

    // R11: issue and writeback of r7 in one cycle, issue wins
    clearSlots();
    setSlot(0,0,1,2,7); wbValid = 1'b1; wbTag = 5'd7;
    step("R11", 1);
    clearSlots();
    setSlot(0,0,7,2,0);
    step("R11", 0);
    wbValid = 1'b1; wbTag = 5'd7;
    step("R11", 0);
    wbValid = 1'b0;
    step("R11", 1);

    // R12: tag 0 never a dependency nor busy
    clearSlots();
    setSlot(0,0,1,2,0); setSlot(1,0,0,0,0);
    step("R12", 2);
    clearSlots();
    setSlot(0,1,0,0,0);
    step("R12", 1);

    // R8: busy source stalls that slot and all later ones
    clearSlots();
    setSlot(0,0,1,2,9);
    step("R8", 1);
    clearSlots();
    setSlot(0,0,1,2,0); setSlot(1,1,9,2,0); setSlot(2,1,1,2,0);
    step("R8", 1);
    clearSlots(); wbValid = 1'b1; wbTag = 5'd9;
    step("R8", 0);

    // R6: random windows against the model
    for (int k = 0; k < 3000; k++) begin
      clearSlots();
      for (int i = 0; i < NS; i++) begin
        if ($urandom_range(0, 9) != 0)
          setSlot(i, $urandom_range(0,3), $urandom_range(0,7),
                  $urandom_range(0,7), $urandom_range(0,7));
      end
      wbValid = ($urandom_range(0,1) == 1);
      wbTag   = TW'($urandom_range(0,7));
      step("R6", -1);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule